// File: doc/BRIEF.md
# Change-of-State Digital Input Controller

This peripheral samples 48 input-only digital lines and presents them to a host over a small byte-wide register bus with a 3-bit address. The lines are grouped eight at a time. Each group can be armed for change detection: once armed, any level transition on any of its eight lines, rising or falling, latches a pending flag for that group and drives a shared, active-high interrupt line.

Software arms groups by writing a 6-bit mask to the control/status address. It services an interrupt by reading that same address. The read returns the pending group flags together with an active-low "this device is interrupting" bit, and it acknowledges them all in one step. The six input bytes sit at fixed offsets inside the eight-byte window, with a hole at offset 3. Every input passes through a two-stage synchroniser before it is read back or compared.

Top module: `cos_input_ctrl`

## Requirements
- R1: After reset the arm mask is 0, no group flag is pending, `irqOut` is low, and a status read (offset 7) returns 0x40.
- R2: The input bytes are read at offsets 0, 1, 2, 4, 5 and 6 for groups 0 to 5. Bit n of group g's byte equals `pinsIn[8g+n]`. A level change appears in the read data two clock edges after it is applied.
- R3: A read of offset 3 returns 0x00. Bit 7 of a status read is always 0. `busRdata` is 0x00 whenever `busRd` is low.
- R4: A write to offset 7 loads `busWdata[5:0]` into the arm mask, where bit k arms group k. A write to any of offsets 0 to 6 changes neither the arm mask, the flags nor the readback.
- R5: In an armed group, a rising edge and a falling edge on any single line each set that group's flag.
- R6: A group that is not armed never latches a flag, whatever its lines do.
- R7: Bits 5:0 of a status read hold the pending group flags. Bit 6 is 0 when any flag is pending and 1 when none is.
- R8: `irqOut` is high exactly while at least one group flag is pending.
- R9: A status read clears every flag on the following clock edge. A change detected in the same cycle as the read stays latched and shows on the next status read.
- R10: Writing a 0 to a group's arm bit clears that group's pending flag at the same edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| busAddr | input | 3 | Byte address within the register window |
| busWr | input | 1 | Write strobe, one cycle per access |
| busRd | input | 1 | Read strobe, one cycle per access; a status read acknowledges |
| busWdata | input | 8 | Write data |
| busRdata | output | 8 | Read data, combinational, valid while busRd is high |
| pinsIn | input | 48 | Asynchronous digital inputs |
| irqOut | output | 1 | Active-high interrupt request |

## Verification
On every cycle the assertions check four things. Pending flags stay inside the arm mask, and a new flag only ever comes from a detected change in an armed group. The status interrupt bit is always the inverse of `irqOut`. The arm mask changes only on a write to offset 7. A status read leaves behind only changes caught in that same cycle. Other behaviour can only be shown by the bench's scenarios: the exact mapping of every input line to its byte offset and bit, both edge polarities on every line of every group, and the two-edge synchroniser latency seen at the ports. The same goes for a change landing exactly on the acknowledging read, and the ordering in which arming, disarming and acknowledging interact.

// File: rtl/cos_pkg.sv
package cos_pkg;
  localparam int unsigned ADDR_W   = 3;
  localparam int unsigned DATA_W   = 8;
  localparam logic [ADDR_W-1:0] STATUS_ADDR = 3'd7;
  localparam int unsigned IRQ_N_BIT = 6;

  typedef struct packed {
    logic              loadArm;
    logic              ackStatus;
    logic              rdValid;
    logic [ADDR_W-1:0] rdSel;
  } cos_strobes_t;

  // Byte offset of input group g: the window skips offset 3.
  function automatic logic [ADDR_W-1:0] groupOffset(input int unsigned g);
    int unsigned off;
    off = (g < 3) ? g : g + 1;
    return off[ADDR_W-1:0];
  endfunction
endpackage

// File: rtl/cos_bus_ctrl.sv
module cos_bus_ctrl
  import cos_pkg::*;
(
  input  logic [ADDR_W-1:0] busAddr,
  input  logic              busWr,
  input  logic              busRd,
  output cos_strobes_t      strobes
);
  logic hitStatus;

  always_comb begin
    hitStatus         = (busAddr == STATUS_ADDR);
    strobes.loadArm   = busWr && hitStatus;
    strobes.ackStatus = busRd && hitStatus;
    strobes.rdValid   = busRd;
    strobes.rdSel     = busAddr;
  end
endmodule

// File: rtl/cos_datapath.sv
module cos_datapath
  import cos_pkg::*;
#(
  parameter int unsigned GROUPS  = 6,
  parameter int unsigned GROUP_W = 8,
  localparam int unsigned PINS   = GROUPS * GROUP_W
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [PINS-1:0]   pinsIn,
  input  cos_strobes_t      strobes,
  input  logic [DATA_W-1:0] busWdata,
  output logic [DATA_W-1:0] busRdata,
  output logic [GROUPS-1:0] armQ,
  output logic [GROUPS-1:0] flagsQ,
  output logic [GROUPS-1:0] chgGroups,
  output logic              irqOut
);
  logic [PINS-1:0]   meta1Q;
  logic [PINS-1:0]   syncQ;
  logic [PINS-1:0]   prevQ;
  logic [GROUPS-1:0] armNext;
  logic [GROUPS-1:0] flagsNext;

  // Two-stage synchroniser followed by a one-cycle history register.
  always_ff @(posedge clk) begin
    if (!rstN) begin
      meta1Q <= '0;
      syncQ  <= '0;
      prevQ  <= '0;
    end else begin
      meta1Q <= pinsIn;
      syncQ  <= meta1Q;
      prevQ  <= syncQ;
    end
  end

  // Any-edge detection, reduced per group.
  for (genvar g = 0; g < GROUPS; g++) begin : g_detect
    assign chgGroups[g] = |(syncQ[g*GROUP_W +: GROUP_W] ^ prevQ[g*GROUP_W +: GROUP_W]);
  end

  always_comb begin
    armNext   = strobes.loadArm ? busWdata[GROUPS-1:0] : armQ;
    flagsNext = strobes.ackStatus ? '0 : flagsQ;
    flagsNext = (flagsNext | (chgGroups & armQ)) & armNext;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      armQ   <= '0;
      flagsQ <= '0;
    end else begin
      armQ   <= armNext;
      flagsQ <= flagsNext;
    end
  end

  assign irqOut = |flagsQ;

  // Read multiplexer.
  always_comb begin
    busRdata = '0;
    if (strobes.rdValid) begin
      if (strobes.rdSel == STATUS_ADDR) begin
        busRdata[GROUPS-1:0] = flagsQ;
        busRdata[IRQ_N_BIT]  = ~irqOut;
      end else begin
        for (int unsigned p = 0; p < GROUPS; p++) begin
          if (strobes.rdSel == groupOffset(p)) begin
            busRdata = syncQ[p*GROUP_W +: GROUP_W];
          end
        end
      end
    end
  end
endmodule

// File: rtl/cos_input_ctrl.sv
module cos_input_ctrl
  import cos_pkg::*;
#(
  parameter int unsigned GROUPS  = 6,
  parameter int unsigned GROUP_W = 8
) (
  input  logic                       clk,
  input  logic                       rstN,
  input  logic [2:0]                 busAddr,
  input  logic                       busWr,
  input  logic                       busRd,
  input  logic [7:0]                 busWdata,
  output logic [7:0]                 busRdata,
  input  logic [GROUPS*GROUP_W-1:0]  pinsIn,
  output logic                       irqOut
);
  cos_strobes_t      strobes;
  logic [GROUPS-1:0] armQ;
  logic [GROUPS-1:0] flagsQ;
  logic [GROUPS-1:0] chgGroups;

  cos_bus_ctrl u_ctrl (
    .busAddr (busAddr),
    .busWr   (busWr),
    .busRd   (busRd),
    .strobes (strobes)
  );

  cos_datapath #(.GROUPS(GROUPS), .GROUP_W(GROUP_W)) u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .pinsIn    (pinsIn),
    .strobes   (strobes),
    .busWdata  (busWdata),
    .busRdata  (busRdata),
    .armQ      (armQ),
    .flagsQ    (flagsQ),
    .chgGroups (chgGroups),
    .irqOut    (irqOut)
  );
endmodule

// File: rtl/cos_checker.sv
module cos_checker #(
  parameter int unsigned GROUPS = 6
) (
  input logic              clk,
  input logic              rstN,
  input logic [2:0]        busAddr,
  input logic              busWr,
  input logic              busRd,
  input logic [7:0]        busWdata,
  input logic [7:0]        busRdata,
  input logic              irqOut,
  input logic [GROUPS-1:0] armQ,
  input logic [GROUPS-1:0] flagsQ,
  input logic [GROUPS-1:0] chgGroups
);
  logic statusRd;
  logic armWr;
  assign statusRd = busRd && (busAddr == 3'd7);
  assign armWr    = busWr && (busAddr == 3'd7);

  p_flag_in_arm_r6: assert property (@(posedge clk) disable iff (!rstN)
    (flagsQ & ~armQ) == '0);

  p_new_flag_source_r6: assert property (@(posedge clk) disable iff (!rstN)
    1'b1 |=> ((flagsQ & ~$past(flagsQ)) & ~($past(chgGroups) & $past(armQ))) == '0);

  p_status_irq_r7: assert property (@(posedge clk) disable iff (!rstN)
    statusRd |-> (busRdata[6] != irqOut));

  p_pad_zero_r3: assert property (@(posedge clk) disable iff (!rstN)
    (busRd && busAddr == 3'd3) |-> busRdata == 8'h00);

  p_status_b7_r3: assert property (@(posedge clk) disable iff (!rstN)
    statusRd |-> !busRdata[7]);

  p_arm_load_r4: assert property (@(posedge clk) disable iff (!rstN)
    armWr |=> armQ == $past(busWdata[GROUPS-1:0]));

  p_arm_hold_r4: assert property (@(posedge clk) disable iff (!rstN)
    !armWr |=> $stable(armQ));

  p_ack_clear_r9: assert property (@(posedge clk) disable iff (!rstN)
    (statusRd && !busWr) |=> flagsQ == ($past(chgGroups) & $past(armQ)));
endmodule

bind cos_input_ctrl cos_checker #(.GROUPS(GROUPS)) u_chk (
  .clk       (clk),
  .rstN      (rstN),
  .busAddr   (busAddr),
  .busWr     (busWr),
  .busRd     (busRd),
  .busWdata  (busWdata),
  .busRdata  (busRdata),
  .irqOut    (irqOut),
  .armQ      (armQ),
  .flagsQ    (flagsQ),
  .chgGroups (chgGroups)
);

// File: tb/tb_cos_input_ctrl.sv
`timescale 1ns/1ps
module tb_cos_input_ctrl;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [2:0]  busAddr = '0;
  logic        busWr = 1'b0;
  logic        busRd = 1'b0;
  logic [7:0]  busWdata = '0;
  logic [7:0]  busRdata;
  logic [47:0] pinsIn = '0;
  logic        irqOut;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #2 clk = ~clk;

  cos_input_ctrl dut (
    .clk(clk), .rstN(rstN), .busAddr(busAddr), .busWr(busWr), .busRd(busRd),
    .busWdata(busWdata), .busRdata(busRdata), .pinsIn(pinsIn), .irqOut(irqOut)
  );

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=0x%02h expected=0x%02h", req, act, exp);
    end
  endtask

  task automatic busRead(input logic [2:0] a, output logic [7:0] d);
    @(negedge clk);
    busAddr = a; busRd = 1'b1;
    #1 d = busRdata;
    @(negedge clk);
    busRd = 1'b0;
  endtask

  task automatic busWrite(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk);
    busAddr = a; busWdata = d; busWr = 1'b1;
    @(negedge clk);
    busWr = 1'b0;
  endtask

  task automatic settle();
    repeat (4) @(negedge clk);
  endtask

  function automatic logic [2:0] offsetOf(input int g);
    return (g < 3) ? 3'(g) : 3'(g + 1);
  endfunction

  initial begin
    logic [7:0] d;
    logic [47:0] pat;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);

    // R1: reset state
    check("R1 irq", {7'd0, irqOut}, 8'h00);
    busRead(3'd7, d); check("R1 status", d, 8'h40);

    // R3: idle read data, pad byte
    #1 check("R3 idle rdata", busRdata, 8'h00);
    pinsIn = '1; settle();
    busRead(3'd3, d); check("R3 offset3", d, 8'h00);

    // R2: readback sweeps with several patterns
    for (int k = 0; k < 4; k++) begin
      pat = (k == 0) ? 48'h0123_4567_89AB : (k == 1) ? 48'hFEDC_BA98_7654 :
            (k == 2) ? 48'h5555_AAAA_0FF0 : 48'h0000_0000_0000;
      pinsIn = pat; settle();
      for (int g = 0; g < 6; g++) begin
        busRead(offsetOf(g), d);
        check("R2 readback", d, pat[g*8 +: 8]);
      end
    end
    // R2: walking one on every line
    for (int i = 0; i < 48; i++) begin
      pinsIn = 48'd1 << i; settle();
      busRead(offsetOf(i / 8), d);
      check("R2 walk", d, 8'd1 << (i % 8));
    end
    // R2: two-edge latency
    pinsIn = '0; settle();
    @(negedge clk); pinsIn[0] = 1'b1;
    @(negedge clk); busAddr = 3'd0; busRd = 1'b1; #1 check("R2 latency one edge", busRdata, 8'h00);
    @(negedge clk); #1 check("R2 latency two edges", busRdata, 8'h01);
    busRd = 1'b0;
    pinsIn = '0; settle();

    // R6 and R4: unarmed changes and writes to 0..6 have no effect
    for (int a = 0; a < 7; a++) busWrite(3'(a), 8'hFF);
    pinsIn = 48'hFFFF_FFFF_FFFF; settle();
    check("R6 irq unarmed", {7'd0, irqOut}, 8'h00);
    busRead(3'd7, d); check("R4 status after ignored writes", d, 8'h40);
    busRead(3'd1, d); check("R4 readback after ignored writes", d, 8'hFF);
    pinsIn = '0; settle();

    // R5/R7/R8/R9: every line, both edges, its group only armed
    for (int i = 0; i < 48; i++) begin
      int g;
      g = i / 8;
      busWrite(3'd7, 8'd1 << g);
      for (int e = 0; e < 2; e++) begin
        pinsIn[i] = ~pinsIn[i]; settle();
        check(e == 0 ? "R5 rise irq" : "R5 fall irq", {7'd0, irqOut}, 8'h01);
        busRead(3'd7, d); check("R7 status flags", d, 8'd1 << g);
        check("R8 irq after ack", {7'd0, irqOut}, 8'h00);
        busRead(3'd7, d); check("R9 cleared", d, 8'h40);
      end
    end

    // R6: change in another group while only group 2 armed
    busWrite(3'd7, 8'h04);
    pinsIn[5] = 1'b1; pinsIn[47] = 1'b1; settle();
    busRead(3'd7, d); check("R6 other groups ignored", d, 8'h40);

    // R9: change detected in same cycle as acknowledging read
    busWrite(3'd7, 8'h01);
    pinsIn = '0; settle();
    busRead(3'd7, d);
    @(negedge clk); pinsIn[3] = 1'b1;
    @(negedge clk);
    @(negedge clk); busAddr = 3'd7; busRd = 1'b1; #1 check("R9 before", busRdata, 8'h40);
    @(negedge clk); busRd = 1'b0;
    check("R9 kept irq", {7'd0, irqOut}, 8'h01);
    busRead(3'd7, d); check("R9 kept flag", d, 8'h01);

    // R10: disarming clears the group's pending flag
    busWrite(3'd7, 8'h03);
    pinsIn[3] = 1'b0; pinsIn[9] = 1'b1; settle();
    busWrite(3'd7, 8'h02);
    busRead(3'd7, d); check("R10 disarm clears", d, 8'h02);
    busWrite(3'd7, 8'h02);
    pinsIn[9] = 1'b0; settle();
    busWrite(3'd7, 8'h00);
    check("R10 irq drops", {7'd0, irqOut}, 8'h00);
    busRead(3'd7, d); check("R10 status", d, 8'h40);

    if (!done) begin
      done = 1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1;
      checks++; errors++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule